// File: doc/BRIEF.md
# ADC Result Error Window Comparator

This block sits behind the post-conversion computation stage of an analog-to-digital converter. Each time the computation stage strobes that a result is ready for testing, the block forms a signed error value from one of five sources: the new result against the result before it, the result against a setpoint, the result against the filter output, the step between successive filter outputs, or the filter output against a setpoint. The error is computed one bit wider than the 16-bit signed error register and clamped into it. Any clamp raises a one-cycle overflow pulse for the shared overflow status.

The stored error is compared, as a signed number, against a programmable upper and lower threshold. The result drives an above-upper flag and a below-lower flag. A sticky threshold flag sets when a condition chosen by a 3-bit interrupt mode holds, and only a software clear drops it. An enable gates the interrupt output. When stop-on-interrupt is enabled, a one-cycle stop request accompanies each new setting of the flag, so that a continuously sampling converter can halt. With double sampling on, only the second conversion of a pair is tested.

Top module: `adc_err_window`

## Requirements
- R1: After reset err_val is 0 and above_upper, below_lower, ovf_set, thr_flag, thr_irq and stop_req are all low; the held previous result and held previous filter value are 0.
- R2: A qualified strobe (test_rdy high and either dbl_en low or second_of_pair high) loads err_val at that clock edge. The calc_sel codes are: 0 = res_in minus held result, 1 = res_in minus setpt, 2 = res_in minus filt_in, 3 = filt_in minus held filter value, 4 = filt_in minus setpt. Codes 5 to 7 give 0.
- R3: On every test_rdy strobe, qualified or not, the held result takes res_in and the held filter value takes filt_in, so the next strobe sees them as the previous values.
- R4: The difference is formed on 17 bits and saturated to the range -32768 to 32767. When saturation occurs, ovf_set is high for exactly the one cycle that follows the strobe edge.
- R5: On each qualified strobe, above_upper is loaded with (error > upper_thr) and below_lower with (error < lower_thr), using signed comparison. Both hold their values between qualified strobes.
- R6: A qualified strobe sets thr_flag when the int_sel condition holds. The int_sel codes are: 0 always; 1 error > upper; 2 error <= upper; 3 error < lower or error > upper; 4 error > lower and error < upper; 5 error >= lower; 6 error < lower; 7 never.
- R7: thr_flag stays set until sw_clr is high at a clock edge. When a setting strobe and sw_clr occur in the same cycle, the flag ends set.
- R8: thr_irq is high exactly when thr_flag is set and int_en is high.
- R9: When stop_on_int is high and thr_flag goes from clear to set, stop_req is high for one cycle. It is low while the flag stays set.
- R10: A test_rdy strobe with dbl_en high and second_of_pair low leaves err_val, above_upper, below_lower, ovf_set and thr_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_rdy | input | 1 | Result-ready strobe from the computation stage |
| dbl_en | input | 1 | Double sampling enabled |
| second_of_pair | input | 1 | Current strobe carries the second conversion of a pair |
| calc_sel | input | 3 | Error source select |
| res_in | input | 16 | New conversion result, signed |
| filt_in | input | 16 | Current filter output, signed |
| setpt | input | 16 | Setpoint, signed |
| upper_thr | input | 16 | Upper threshold, signed |
| lower_thr | input | 16 | Lower threshold, signed |
| int_sel | input | 3 | Interrupt condition select |
| int_en | input | 1 | Interrupt output enable |
| stop_on_int | input | 1 | Request a stop when the flag newly sets |
| sw_clr | input | 1 | Software clear of the threshold flag |
| err_val | output | 16 | Stored error, signed |
| above_upper | output | 1 | Last tested error exceeded the upper threshold |
| below_lower | output | 1 | Last tested error was below the lower threshold |
| ovf_set | output | 1 | One-cycle pulse when the error saturated |
| thr_flag | output | 1 | Sticky threshold flag |
| thr_irq | output | 1 | Gated threshold interrupt |
| stop_req | output | 1 | One-cycle stop request |

## Verification
A corrupted held result or held filter value does not show at the strobe that stores it. It shows as a wrong err_val one strobe later, in calc_sel 0 or 3 only. For this reason the bench strings strobes together and checks err_val after every one, including strobes that are not qualified. A wrong flag or threshold state is visible in the cycle after the qualifying edge. Because the flag is sticky, a spurious set stays visible at thr_flag until the next clear. This means each interrupt-mode case starts from a cleared flag, and cases near the thresholds are probed at the boundary values exactly.

// File: rtl/adc_errwin_pkg.sv
package adc_errwin_pkg;
   typedef enum logic [2:0] {
      ERR_RES_STEP   = 3'd0,
      ERR_RES_SETPT  = 3'd1,
      ERR_RES_FILT   = 3'd2,
      ERR_FILT_STEP  = 3'd3,
      ERR_FILT_SETPT = 3'd4
   } err_src_e;

   typedef enum logic [2:0] {
      IRQ_ALWAYS    = 3'd0,
      IRQ_ABOVE_UP  = 3'd1,
      IRQ_NOT_ABOVE = 3'd2,
      IRQ_OUTSIDE   = 3'd3,
      IRQ_INSIDE    = 3'd4,
      IRQ_NOT_BELOW = 3'd5,
      IRQ_BELOW_LO  = 3'd6,
      IRQ_NEVER     = 3'd7
   } irq_mode_e;
endpackage

// File: rtl/adc_errwin_src.sv
module adc_errwin_src
   import adc_errwin_pkg::*;
#(
   parameter int DW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [2:0]           calc_sel,
   input  logic signed [DW-1:0] res_in,
   input  logic signed [DW-1:0] filt_in,
   input  logic signed [DW-1:0] setpt,
   output logic signed [DW-1:0] err,
   output logic                 range_hit
);
   localparam int XW = DW + 1;
   localparam logic signed [DW-1:0] ERR_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] ERR_MIN = {1'b1, {(DW-1){1'b0}}};

   initial begin : chk_params
      assert (DW >= 4) else $fatal(1, "adc_errwin_src: DW must be at least 4");
   end

   logic signed [DW-1:0] cur_q, pfilt_q, op_a, op_b;
   logic signed [XW-1:0] diff;

   // held values shift on every strobe, qualified or not (R3)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         pfilt_q <= '0;
      end else if (capture) begin
         cur_q   <= res_in;
         pfilt_q <= filt_in;
      end
   end

   always_comb begin
      case (calc_sel)
         ERR_RES_STEP:   begin op_a = res_in;  op_b = cur_q;   end
         ERR_RES_SETPT:  begin op_a = res_in;  op_b = setpt;   end
         ERR_RES_FILT:   begin op_a = res_in;  op_b = filt_in; end
         ERR_FILT_STEP:  begin op_a = filt_in; op_b = pfilt_q; end
         ERR_FILT_SETPT: begin op_a = filt_in; op_b = setpt;   end
         default:        begin op_a = '0;      op_b = '0;      end
      endcase
   end

   assign diff      = {op_a[DW-1], op_a} - {op_b[DW-1], op_b};
   assign range_hit = diff[XW-1] ^ diff[XW-2];

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (range_hit) err = diff[XW-1] ? ERR_MIN : ERR_MAX;
            else           err = diff[DW-1:0];
         end
      end else begin : g_wrap
         assign err = diff[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/adc_errwin_cmp.sv
module adc_errwin_cmp
   import adc_errwin_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic signed [DW-1:0] err,
   input  logic signed [DW-1:0] upper_thr,
   input  logic signed [DW-1:0] lower_thr,
   input  logic [2:0]           int_sel,
   output logic                 above,
   output logic                 below,
   output logic                 hit
);
   logic gt_up, lt_up, gt_lo;

   assign gt_up = err > upper_thr;
   assign lt_up = err < upper_thr;
   assign gt_lo = err > lower_thr;
   assign above = gt_up;
   assign below = err < lower_thr;

   always_comb begin
      case (int_sel)
         IRQ_ALWAYS:    hit = 1'b1;
         IRQ_ABOVE_UP:  hit = gt_up;
         IRQ_NOT_ABOVE: hit = !gt_up;
         IRQ_OUTSIDE:   hit = below | gt_up;
         IRQ_INSIDE:    hit = gt_lo & lt_up;
         IRQ_NOT_BELOW: hit = !below;
         IRQ_BELOW_LO:  hit = below;
         default:       hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/adc_errwin_flag.sv
module adc_errwin_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic eval,
   input  logic hit,
   input  logic sw_clr,
   input  logic stop_en,
   output logic flag,
   output logic stop_req
);
   logic set_now;

   assign set_now = eval & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag     <= 1'b0;
         stop_req <= 1'b0;
      end else begin
         if (set_now)     flag <= 1'b1;
         else if (sw_clr) flag <= 1'b0;
         stop_req <= set_now & !flag & stop_en;
      end
   end

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !sw_clr) |=> flag);
   p_stop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !stop_req);
   p_stop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> (flag && !$past(flag)));
endmodule

// File: rtl/adc_err_window.sv
module adc_err_window
   import adc_errwin_pkg::*;
#(
   parameter int DW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 test_rdy,
   input  logic                 dbl_en,
   input  logic                 second_of_pair,
   input  logic [2:0]           calc_sel,
   input  logic signed [DW-1:0] res_in,
   input  logic signed [DW-1:0] filt_in,
   input  logic signed [DW-1:0] setpt,
   input  logic signed [DW-1:0] upper_thr,
   input  logic signed [DW-1:0] lower_thr,
   input  logic [2:0]           int_sel,
   input  logic                 int_en,
   input  logic                 stop_on_int,
   input  logic                 sw_clr,
   output logic signed [DW-1:0] err_val,
   output logic                 above_upper,
   output logic                 below_lower,
   output logic                 ovf_set,
   output logic                 thr_flag,
   output logic                 thr_irq,
   output logic                 stop_req
);
   localparam logic signed [DW-1:0] ERR_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] ERR_MIN = {1'b1, {(DW-1){1'b0}}};

   logic                 accept, range_hit, above_c, below_c, hit_c;
   logic signed [DW-1:0] err_c;

   assign accept = test_rdy & (!dbl_en | second_of_pair);

   adc_errwin_src #(.DW(DW), .SATURATE(SATURATE)) u_src (
      .clk(clk), .rst_n(rst_n), .capture(test_rdy), .calc_sel(calc_sel),
      .res_in(res_in), .filt_in(filt_in), .setpt(setpt),
      .err(err_c), .range_hit(range_hit));

   adc_errwin_cmp #(.DW(DW)) u_cmp (
      .err(err_c), .upper_thr(upper_thr), .lower_thr(lower_thr),
      .int_sel(int_sel), .above(above_c), .below(below_c), .hit(hit_c));

   adc_errwin_flag u_flag (
      .clk(clk), .rst_n(rst_n), .eval(accept), .hit(hit_c), .sw_clr(sw_clr),
      .stop_en(stop_on_int), .flag(thr_flag), .stop_req(stop_req));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_val     <= '0;
         above_upper <= 1'b0;
         below_lower <= 1'b0;
         ovf_set     <= 1'b0;
      end else begin
         ovf_set <= accept & range_hit;
         if (accept) begin
            err_val     <= err_c;
            above_upper <= above_c;
            below_lower <= below_c;
         end
      end
   end

   assign thr_irq = thr_flag & int_en;

   p_first_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (test_rdy && dbl_en && !second_of_pair) |=>
         ($stable(err_val) && $stable(above_upper) && $stable(below_lower) && !ovf_set));
   p_always_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && int_sel == IRQ_ALWAYS) |=> thr_flag);
   p_never_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && int_sel == IRQ_NEVER && !thr_flag) |=> !thr_flag);

   generate
      if (SATURATE) begin : g_sat_chk
         p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_set |-> (err_val == ERR_MAX || err_val == ERR_MIN));
      end
   endgenerate
endmodule

// File: tb/tb_adc_err_window.sv
module tb_adc_err_window;
   logic clk = 1'b0;
   logic rst_n, test_rdy, dbl_en, second_of_pair, int_en, stop_on_int, sw_clr;
   logic [2:0] calc_sel, int_sel;
   logic signed [15:0] res_in, filt_in, setpt, upper_thr, lower_thr;
   logic signed [15:0] err_val;
   logic above_upper, below_lower, ovf_set, thr_flag, thr_irq, stop_req;

   int n_chk = 0, n_fail = 0;
   int m_cur = 0, m_pf = 0;
   int e_err = 0;
   bit e_ovf = 1'b0;

   always #2 clk = ~clk;

   adc_err_window dut (
      .clk(clk), .rst_n(rst_n), .test_rdy(test_rdy), .dbl_en(dbl_en),
      .second_of_pair(second_of_pair), .calc_sel(calc_sel), .res_in(res_in),
      .filt_in(filt_in), .setpt(setpt), .upper_thr(upper_thr), .lower_thr(lower_thr),
      .int_sel(int_sel), .int_en(int_en), .stop_on_int(stop_on_int), .sw_clr(sw_clr),
      .err_val(err_val), .above_upper(above_upper), .below_lower(below_lower),
      .ovf_set(ovf_set), .thr_flag(thr_flag), .thr_irq(thr_irq), .stop_req(stop_req));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit mode_hit(input int m, input int e);
      case (m)
         0: return 1'b1;
         1: return e > 100;
         2: return e <= 100;
         3: return (e < -100) || (e > 100);
         4: return (e > -100) && (e < 100);
         5: return e >= -100;
         6: return e < -100;
         default: return 1'b0;
      endcase
   endfunction

   task automatic pulse(input int r, input int f, input bit sec);
      int d;
      @(negedge clk);
      res_in = 16'(r); filt_in = 16'(f); second_of_pair = sec; test_rdy = 1'b1;
      if (!dbl_en || sec) begin
         case (calc_sel)
            3'd0: d = r - m_cur;
            3'd1: d = r - int'(setpt);
            3'd2: d = r - f;
            3'd3: d = f - m_pf;
            3'd4: d = f - int'(setpt);
            default: d = 0;
         endcase
         e_ovf = 1'b0;
         if (d > 32767)  begin d = 32767;  e_ovf = 1'b1; end
         if (d < -32768) begin d = -32768; e_ovf = 1'b1; end
         e_err = d;
      end else e_ovf = 1'b0;
      m_cur = r; m_pf = f;
      @(negedge clk);
      test_rdy = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); sw_clr = 1'b1;
      @(negedge clk); sw_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 err", int'(err_val), 0);
      chk("R1 above", above_upper, 0);
      chk("R1 below", below_lower, 0);
      chk("R1 ovf", ovf_set, 0);
      chk("R1 flag", thr_flag, 0);
      chk("R1 irq", thr_irq, 0);
      chk("R1 stop", stop_req, 0);
   endtask

   task automatic t_modes();
      int_sel = 3'd7; setpt = 16'sd50;
      calc_sel = 3'd0; pulse(300, 40, 0);  chk("R2 mode0 from reset", int'(err_val), e_err);
      pulse(120, 70, 0);                    chk("R3 mode0 step", int'(err_val), e_err);
      calc_sel = 3'd1; pulse(-20, 10, 0);  chk("R2 mode1", int'(err_val), e_err);
      calc_sel = 3'd2; pulse(500, 650, 0); chk("R2 mode2", int'(err_val), e_err);
      calc_sel = 3'd3; pulse(0, 600, 0);   chk("R3 mode3 filter step", int'(err_val), e_err);
      pulse(0, 900, 0);                     chk("R3 mode3 filter step 2", int'(err_val), e_err);
      calc_sel = 3'd4; pulse(0, -75, 0);   chk("R2 mode4", int'(err_val), e_err);
      calc_sel = 3'd6; pulse(777, 333, 0); chk("R2 reserved code", int'(err_val), 0);
   endtask

   task automatic t_sat();
      calc_sel = 3'd1; setpt = -16'sd10000;
      pulse(30000, 0, 0);
      chk("R4 positive clamp", int'(err_val), 32767);
      chk("R4 ovf pulse", ovf_set, 1);
      @(negedge clk); chk("R4 ovf single cycle", ovf_set, 0);
      setpt = 16'sd10000;
      pulse(-30000, 0, 0);
      chk("R4 negative clamp", int'(err_val), -32768);
      chk("R4 ovf pulse neg", ovf_set, 1);
      pulse(100, 0, 0);
      chk("R4 no ovf in range", ovf_set, 0);
   endtask

   task automatic t_compare();
      calc_sel = 3'd1; setpt = 16'sd0;
      pulse(150, 0, 0);  chk("R5 above", above_upper, 1); chk("R5 not below", below_lower, 0);
      pulse(-150, 0, 0); chk("R5 below", below_lower, 1); chk("R5 not above", above_upper, 0);
      pulse(100, 0, 0);  chk("R5 equal upper not above", above_upper, 0);
      pulse(-100, 0, 0); chk("R5 equal lower not below", below_lower, 0);
      pulse(-30000, 0, 0);
      repeat (3) @(negedge clk);
      chk("R5 hold between strobes", below_lower, 1);
   endtask

   task automatic t_irqmodes();
      int vals[7] = '{-200, -101, -100, 0, 100, 101, 200};
      calc_sel = 3'd1; setpt = 16'sd0; int_en = 1'b0;
      for (int m = 0; m < 8; m++) begin
         foreach (vals[i]) begin
            clear_flag();
            int_sel = 3'(m);
            pulse(vals[i], 0, 0);
            chk($sformatf("R6 mode %0d err %0d", m, vals[i]), thr_flag, int'(mode_hit(m, vals[i])));
         end
      end
   endtask

   task automatic t_sticky_irq();
      calc_sel = 3'd1; setpt = 16'sd0;
      clear_flag();
      int_en = 1'b0; int_sel = 3'd0;
      pulse(5, 0, 0);
      chk("R8 irq masked", thr_irq, 0);
      @(negedge clk); int_en = 1'b1; #1;
      chk("R8 irq enabled", thr_irq, 1);
      int_sel = 3'd7;
      pulse(5, 0, 0);
      repeat (2) @(negedge clk);
      chk("R7 flag sticky", thr_flag, 1);
      int_sel = 3'd0;
      @(negedge clk); sw_clr = 1'b1; test_rdy = 1'b1; res_in = 16'sd9; m_cur = 9; m_pf = int'(filt_in);
      @(negedge clk); sw_clr = 1'b0; test_rdy = 1'b0;
      chk("R7 set wins over clear", thr_flag, 1);
      clear_flag();
      chk("R7 clear", thr_flag, 0);
      chk("R8 irq follows flag", thr_irq, 0);
      int_en = 1'b0;
   endtask

   task automatic t_stop();
      calc_sel = 3'd1; setpt = 16'sd0; int_sel = 3'd0; stop_on_int = 1'b1;
      clear_flag();
      pulse(1, 0, 0);
      chk("R9 stop on new set", stop_req, 1);
      @(negedge clk); chk("R9 stop one cycle", stop_req, 0);
      pulse(1, 0, 0);
      chk("R9 no stop when already set", stop_req, 0);
      stop_on_int = 1'b0;
      clear_flag();
      pulse(1, 0, 0);
      chk("R9 no stop when disabled", stop_req, 0);
   endtask

   task automatic t_pair();
      calc_sel = 3'd0; int_sel = 3'd0; dbl_en = 1'b1;
      pulse(40, 0, 1);
      clear_flag();
      pulse(1000, 0, 0);
      chk("R10 first of pair err hold", int'(err_val), e_err);
      chk("R10 first of pair no flag", thr_flag, 0);
      pulse(1300, 0, 1);
      chk("R3 second minus first", int'(err_val), 300);
      chk("R10 second of pair sets flag", thr_flag, 1);
      dbl_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; test_rdy = 1'b0; dbl_en = 1'b0; second_of_pair = 1'b0;
      int_en = 1'b0; stop_on_int = 1'b0; sw_clr = 1'b0;
      calc_sel = 3'd0; int_sel = 3'd7;
      res_in = '0; filt_in = '0; setpt = '0;
      upper_thr = 16'sd100; lower_thr = -16'sd100;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_sat();
      t_compare();
      t_irqmodes();
      t_sticky_irq();
      t_stop();
      t_pair();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule